// File: doc/BRIEF.md
# Fractional-N PLL rate calculator

This block works out the output frequency that a fractional-N PLL will produce from a given set of divider fields and a reference frequency. The caller presents the reference rate in hertz, the integer multiplier, the fractional numerator and denominator, the pre-divider code and the post-divider code, then pulses `start`. Some cycles later the block raises `done` for one cycle, with the rate in hertz on `rate_hz`.

Before it does any arithmetic, the block compares the five fields with a small built-in list of preset configurations. On an exact match it returns the listed rate at once. This gives an exact figure for presets whose fractional part would otherwise be truncated. When no preset matches, it forms an integer numerator and denominator and runs a restoring divider that produces one quotient bit per cycle. A zero denominator field is reported on `err` and no division is run.

Top module: `fracn_rate_calc`

## Requirements
- R1: When no preset matches, `rate_hz` equals floor((Fref·MFI·MFD + Fref·MFN) / (MFD · r · o)). The numerator is formed modulo 2^NUM_W (64 bits by default), and r and o are the decoded divider values.
- R2: A pre-divider code of 0 is decoded as divide-by-1. Any other code c divides by c.
- R3: A post-divider code of 0 divides by 2 and a code of 1 divides by 3. Every other code c divides by c.
- R4: When the fields (MFI, MFN, MFD, pre, post) exactly equal one of the eight presets, `rate_hz` is that preset's listed rate whatever the reference. The presets are:
  - (81,0,1,0,3) gives 650000000
  - (198,0,1,0,8) gives 594000000
  - (70,0,1,0,3) gives 560000000
  - (83,0,1,0,4) gives 498000000
  - (121,0,1,0,6) gives 484000000
  - (167,0,1,0,9) gives 445333333
  - (50,0,1,0,3) gives 400000000
  - (81,92,100,0,5) gives 393216000
- R5: A start with MFD = 0 finishes with `err` = 1 and `rate_hz` = 0. Any accepted start with a non-zero MFD finishes with `err` = 0.
- R6: Latency is counted from the clock edge that accepts `start`. For a preset hit or an error, `done` is high in the cycle right after that edge. For the formula path, `done` is high in the cycle after edge NUM_W+2: one setup cycle, NUM_W quotient-bit cycles, then `done`.
- R7: `done` is a single-cycle pulse. `rate_hz` and `err` hold their values until the next accepted start.
- R8: A `start` pulse that arrives while `busy` is high is ignored, and the running computation finishes with its own result and latency.
- R9: While reset is asserted, `busy`, `done` and `err` are 0 and `rate_hz` is 0.
- R10: `busy` is high from the cycle after an accepted start up to and including the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a computation; sampled only when idle |
| ref_hz | input | REF_W (32) | Reference frequency in Hz |
| mfi | input | MFI_W (9) | Integer multiplier |
| mfn | input | MFN_W (30) | Fractional numerator |
| mfd | input | MFD_W (30) | Fractional denominator |
| rdiv | input | RDV_W (3) | Pre-divider code |
| odiv | input | ODV_W (8) | Post-divider code |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Zero denominator was given |
| rate_hz | output | NUM_W (64) | Output frequency in Hz |

## Verification
Three kinds of input pattern are applied.

- **Preset hits.** Some of these use a reference under which the formula would give a different figure, or a zero reference. They separate "taken from the list" from "computed".
- **Near-misses of a preset.** These differ in one field, such as a non-zero MFN, and must take the formula path with the longer latency.
- **Formula cases.** These cover every special divider code and compare it with its plain equivalent: post code 0 against 2, pre code 0 against 1. They also include fractional settings whose quotient truncates, and the widest divider values.

A zero denominator, a start pulse during a running division and result holding after `done` are driven as directed cases.

// File: rtl/fracn_rate_calc.sv
`timescale 1ns/1ps
module fracn_rate_calc #(
  parameter int REF_W = 32,
  parameter int MFI_W = 9,
  parameter int MFN_W = 30,
  parameter int MFD_W = 30,
  parameter int RDV_W = 3,
  parameter int ODV_W = 8,
  parameter int NUM_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [REF_W-1:0] ref_hz,
  input  logic [MFI_W-1:0] mfi,
  input  logic [MFN_W-1:0] mfn,
  input  logic [MFD_W-1:0] mfd,
  input  logic [RDV_W-1:0] rdiv,
  input  logic [ODV_W-1:0] odiv,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [NUM_W-1:0] rate_hz
);
  localparam int CNT_W = $clog2(NUM_W);
  localparam int KEY_W = MFI_W + MFN_W + MFD_W + RDV_W + ODV_W;

  typedef enum logic [1:0] {S_IDLE, S_PREP, S_DIV, S_FIN} st_t;
  st_t st;

  logic [REF_W-1:0] ref_q;
  logic [MFI_W-1:0] mfi_q;
  logic [MFN_W-1:0] mfn_q;
  logic [MFD_W-1:0] mfd_q;
  logic [RDV_W-1:0] rdiv_q;
  logic [ODV_W-1:0] odiv_q;
  logic [NUM_W-1:0] num_q, den_q, rem_q, res_q;
  logic [CNT_W-1:0] cnt_q;
  logic             err_q;

  wire [KEY_W-1:0] key = {mfi, mfn, mfd, rdiv, odiv};
  logic            hit;
  logic [NUM_W-1:0] hit_rate;

  always_comb begin
    hit = 1'b1;
    hit_rate = '0;
    case (key)
      {MFI_W'(81),  MFN_W'(0),  MFD_W'(1),   RDV_W'(0), ODV_W'(3)}: hit_rate = NUM_W'(650000000);
      {MFI_W'(198), MFN_W'(0),  MFD_W'(1),   RDV_W'(0), ODV_W'(8)}: hit_rate = NUM_W'(594000000);
      {MFI_W'(70),  MFN_W'(0),  MFD_W'(1),   RDV_W'(0), ODV_W'(3)}: hit_rate = NUM_W'(560000000);
      {MFI_W'(83),  MFN_W'(0),  MFD_W'(1),   RDV_W'(0), ODV_W'(4)}: hit_rate = NUM_W'(498000000);
      {MFI_W'(121), MFN_W'(0),  MFD_W'(1),   RDV_W'(0), ODV_W'(6)}: hit_rate = NUM_W'(484000000);
      {MFI_W'(167), MFN_W'(0),  MFD_W'(1),   RDV_W'(0), ODV_W'(9)}: hit_rate = NUM_W'(445333333);
      {MFI_W'(50),  MFN_W'(0),  MFD_W'(1),   RDV_W'(0), ODV_W'(3)}: hit_rate = NUM_W'(400000000);
      {MFI_W'(81),  MFN_W'(92), MFD_W'(100), RDV_W'(0), ODV_W'(5)}: hit_rate = NUM_W'(393216000);
      default: hit = 1'b0;
    endcase
  end

  wire [RDV_W-1:0] rd_eff = (rdiv_q == '0) ? RDV_W'(1) : rdiv_q;
  logic [ODV_W-1:0] od_eff;
  always_comb begin
    case (odiv_q)
      ODV_W'(0): od_eff = ODV_W'(2);
      ODV_W'(1): od_eff = ODV_W'(3);
      default:   od_eff = odiv_q;
    endcase
  end

  wire [NUM_W-1:0] num0 = NUM_W'(ref_q) * NUM_W'(mfi_q) * NUM_W'(mfd_q)
                        + NUM_W'(ref_q) * NUM_W'(mfn_q);
  wire [NUM_W-1:0] den0 = NUM_W'(mfd_q) * NUM_W'(rd_eff) * NUM_W'(od_eff);

  wire [NUM_W:0]   rem_s = {rem_q, num_q[NUM_W-1]};
  wire             ge    = rem_s >= {1'b0, den_q};
  wire [NUM_W:0]   rem_d = rem_s - {1'b0, den_q};
  wire [NUM_W-1:0] rem_n = ge ? rem_d[NUM_W-1:0] : rem_s[NUM_W-1:0];
  wire [NUM_W-1:0] q_n   = {num_q[NUM_W-2:0], ge};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ref_q <= '0; mfi_q <= '0; mfn_q <= '0; mfd_q <= '0; rdiv_q <= '0; odiv_q <= '0;
      num_q <= '0; den_q <= '0; rem_q <= '0; res_q <= '0; cnt_q <= '0; err_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ref_q <= ref_hz; mfi_q <= mfi; mfn_q <= mfn;
          mfd_q <= mfd; rdiv_q <= rdiv; odiv_q <= odiv;
          if (mfd == '0) begin
            err_q <= 1'b1; res_q <= '0; st <= S_FIN;
          end else if (hit) begin
            err_q <= 1'b0; res_q <= hit_rate; st <= S_FIN;
          end else begin
            err_q <= 1'b0; st <= S_PREP;
          end
        end
        S_PREP: begin
          num_q <= num0; den_q <= den0; rem_q <= '0; cnt_q <= '0;
          st <= S_DIV;
        end
        S_DIV: begin
          num_q <= q_n;
          rem_q <= rem_n;
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(NUM_W - 1)) begin
            res_q <= q_n;
            st <= S_FIN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign done    = (st == S_FIN);
  assign err     = err_q;
  assign rate_hz = res_q;
endmodule

module fracn_rate_calc_chk #(
  parameter int NUM_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [NUM_W-1:0] rate_hz
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(err));
  // R5
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && err) |-> (rate_hz == '0));
  // R10
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
endmodule

bind fracn_rate_calc fracn_rate_calc_chk #(.NUM_W(NUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .err(err), .rate_hz(rate_hz)
);

// File: tb/sim_fracn_rate_calc.sv
`timescale 1ns/1ps
module sim_fracn_rate_calc;
  localparam int NUM_W = 64;
  localparam int NV = 11;
  localparam int LONG_LAT = NUM_W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] ref_hz = '0;
  logic [8:0]  mfi = '0;
  logic [29:0] mfn = '0;
  logic [29:0] mfd = '0;
  logic [2:0]  rdiv = '0;
  logic [7:0]  odiv = '0;
  logic busy, done, err;
  logic [NUM_W-1:0] rate_hz;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  fracn_rate_calc u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz), .mfi(mfi),
    .mfn(mfn), .mfd(mfd), .rdiv(rdiv), .odiv(odiv), .busy(busy),
    .done(done), .err(err), .rate_hz(rate_hz)
  );

  // {ref, mfi, mfn, mfd, rdiv, odiv, short_latency, expected}
  localparam logic [176:0] VEC [0:NV-1] = '{
    {32'd24000000,  9'd81,  30'd0,  30'd1,   3'd0, 8'd3,   1'b1, 64'd650000000},
    {32'd25000000,  9'd81,  30'd92, 30'd100, 3'd0, 8'd5,   1'b1, 64'd393216000},
    {32'd0,         9'd167, 30'd0,  30'd1,   3'd0, 8'd9,   1'b1, 64'd445333333},
    {32'd24000000,  9'd100, 30'd0,  30'd1,   3'd0, 8'd0,   1'b0, 64'd1200000000},
    {32'd24000000,  9'd100, 30'd0,  30'd1,   3'd0, 8'd1,   1'b0, 64'd800000000},
    {32'd24000000,  9'd100, 30'd0,  30'd1,   3'd2, 8'd4,   1'b0, 64'd300000000},
    {32'd24000000,  9'd81,  30'd1,  30'd3,   3'd1, 8'd4,   1'b0, 64'd488000000},
    {32'd24000000,  9'd81,  30'd1,  30'd7,   3'd0, 8'd5,   1'b0, 64'd389485714},
    {32'd24000000,  9'd81,  30'd1,  30'd1,   3'd0, 8'd3,   1'b0, 64'd656000000},
    {32'd100000000, 9'd511, 30'd0,  30'd1,   3'd7, 8'd255, 1'b0, 64'd28627450},
    {32'd24000000,  9'd100, 30'd0,  30'd1,   3'd1, 8'd2,   1'b0, 64'd1200000000}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [176:0] v);
    ref_hz = v[176:145]; mfi = v[144:136]; mfn = v[135:106];
    mfd = v[105:76]; rdiv = v[75:73]; odiv = v[72:65];
  endtask

  task automatic run(input logic [176:0] v, output int lat);
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    chk(busy == 1'b1, "R10", 64'(busy), 64'd1);
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    string tag;
    repeat (3) @(negedge clk);
    // R9
    chk(busy == 0 && done == 0 && err == 0, "R9", {61'd0, busy, done, err}, 64'd0);
    chk(rate_hz == 0, "R9", rate_hz, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run(VEC[i], lat);
      if (VEC[i][64]) tag = "R4";
      else if (VEC[i][72:65] < 8'd2) tag = "R3";
      else if (VEC[i][75:73] == 3'd0) tag = "R2";
      else tag = "R1";
      chk(rate_hz == VEC[i][63:0], tag, rate_hz, VEC[i][63:0]);
      chk(err == 1'b0, "R5", 64'(err), 64'd0);
      chk(lat == (VEC[i][64] ? 1 : LONG_LAT), "R6", 64'(lat), 64'(VEC[i][64] ? 1 : LONG_LAT));
      @(negedge clk);
      chk(done == 1'b0, "R7", 64'(done), 64'd0);
    end

    // R7: result holds after done
    repeat (4) @(negedge clk);
    chk(rate_hz == 64'd1200000000, "R7", rate_hz, 64'd1200000000);
    chk(busy == 1'b0, "R10", 64'(busy), 64'd0);

    // R5: zero denominator
    run({32'd24000000, 9'd100, 30'd5, 30'd0, 3'd0, 8'd3, 1'b1, 64'd0}, lat);
    chk(err == 1'b1, "R5", 64'(err), 64'd1);
    chk(rate_hz == 0, "R5", rate_hz, 64'd0);
    chk(lat == 1, "R6", 64'(lat), 64'd1);
    repeat (3) @(negedge clk);
    chk(err == 1'b1, "R7", 64'(err), 64'd1);

    // R5: next valid computation clears err
    run(VEC[4], lat);
    chk(err == 1'b0, "R5", 64'(err), 64'd0);
    chk(rate_hz == 64'd800000000, "R3", rate_hz, 64'd800000000);

    // R8: start while busy is ignored
    @(negedge clk);
    drive(VEC[5]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (5) begin @(negedge clk); lat++; end
    drive(VEC[0]);
    start = 1'b1;
    @(negedge clk);
    lat++;
    start = 1'b0;
    drive(VEC[9]);
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    chk(rate_hz == 64'd300000000, "R8", rate_hz, 64'd300000000);
    chk(lat == LONG_LAT, "R8", 64'(lat), 64'(LONG_LAT));
    @(negedge clk);
    chk(busy == 1'b0, "R8", 64'(busy), 64'd0);
    repeat (3) @(negedge clk);
    chk(rate_hz == 64'd300000000, "R8", rate_hz, 64'd300000000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule